// File: doc/BRIEF.md
# Small-Page NAND Flash Behavioural Model

This block is a synthesizable model of an 8-bit NAND flash device with small pages. It sits behind the usual NAND pin set: command-latch and address-latch enables, an active-low chip enable, an active-low write protect, and a byte-wide data path. A host drives a byte together with a one-cycle write strobe. Depending on the latch enables, that byte is taken as a command opcode, an address byte or program data. Data comes back on a one-cycle read strobe. Every operation completes at once, so the ready/busy output stays high.

Internally the model keeps a small array of pages, each followed by a spare area one thirty-second of the page size. It also keeps a page-wide program buffer and a command/address sequencer. A read streams from a start column through the end of the spare area. Three read opcodes pick the start region: the first half, the second half or the spare area. Programming only clears bits. Erase restores a whole block to 0xFF. The status and identification bytes are answered from the sequencer state.

Top module: `nand_sp_model`

## Requirements
- R1: On a write strobe with ce_n low, a byte with cle high is an opcode and a byte with ale high (cle low) is an address byte. Strobes while ce_n is high have no effect.
- R2: While ce_n is high, dout is 0x00. After reset, dout is 0x00 and rb is 1.
- R3: Opcode 0x00 followed by a column byte and two row bytes (row low byte first) starts a read of page `row`. Each read strobe advances to the next byte.
- R4: Opcode 0x01 adds PAGE_BYTES/2 to the column, and 0x50 adds PAGE_BYTES, so the read begins in the spare area. The added offset applies to the next read or program only. Opcode 0x00 clears it.
- R5: A read stream ends after the last spare byte (column PAGE_BYTES + PAGE_BYTES/32 - 1). Further reads return 0x00.
- R6: Program is opcode 0x80, three address bytes, data bytes, then 0x10. Each byte is ANDed into the page at consecutive columns from the start column. Data past the end of the spare area is dropped, and bytes not written keep their contents.
- R7: Erase is opcode 0x60, two row bytes, then 0xD0. It sets every byte (spare included) of all BLOCK_PAGES pages of the block containing that row to 0xFF, leaving other blocks unchanged.
- R8: While wp_n is low, the 0x10 and 0xD0 confirms leave the array unchanged.
- R9: After opcode 0x70, every read returns the status byte until the next opcode. Status is bit 7 = wp_n, bit 6 = 1 (ready), all other bits 0.
- R10: Opcode 0x90 followed by one address byte makes the next reads return MFR_ID, DEV_ID, ID_PAD and 0xC0, then 0x00.
- R11: Opcode 0xFF abandons any operation and clears address state and the column offset. Reads then return 0x00 until a new read is addressed, and the status still shows ready.
- R12: After reset the array holds 0xFF everywhere. A page at or beyond PAGES reads as 0x00, and program or erase to it leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also fills the array with 0xFF |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| ce_n | input | 1 | Chip enable, active low |
| wp_n | input | 1 | Write protect, active low |
| we | input | 1 | One-cycle write strobe for din |
| re | input | 1 | One-cycle read strobe; advances the output byte |
| din | input | 8 | Opcode, address or program byte |
| dout | output | 8 | Read data, status or ID byte |
| rb | output | 1 | Ready/busy, constantly ready |

## Verification
Most internal faults surface on the very next read strobe. A wrong column pointer or offset shows up as the wrong byte or an early 0x00 in the stream. A lost status mode shows up as array data where the status byte should be. A wrong mode after reset returns stale data instead of 0x00. Array faults are slower to appear: a missing AND, an over-wide erase or a bypassed protect only shows when that page is read back. For that reason every program and erase is followed by a readback that crosses the edited columns, a neighbouring page and the next block.

// File: rtl/nand_sp_model.sv
module nand_sp_model #(
  parameter int PAGE_BYTES  = 64,
  parameter int PAGES       = 32,
  parameter int BLOCK_PAGES = 16,
  parameter logic [7:0] MFR_ID = 8'h2C,
  parameter logic [7:0] DEV_ID = 8'h75,
  parameter logic [7:0] ID_PAD = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       ce_n,
  input  logic       wp_n,
  input  logic       we,
  input  logic       re,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       rb
);
  localparam int SPARE = PAGE_BYTES / 32;
  localparam int ROW   = PAGE_BYTES + SPARE;
  localparam int CELLS = PAGES * ROW;
  localparam int AW    = $clog2(CELLS);
  localparam int RW    = $clog2(ROW);
  localparam int CW    = $clog2(2 * ROW + 256);
  localparam int HALF  = PAGE_BYTES / 2;

  typedef enum logic [2:0] {M_READ, M_ID, M_PROG, M_ERASE, M_STAT, M_IDLE} mode_t;

  mode_t          mode;
  logic [1:0]     acnt;
  logic [7:0]     col;
  logic [15:0]    row;
  logic [CW-1:0]  base;
  logic [CW-1:0]  ptr;
  logic           run;
  logic [2:0]     idx;
  logic [7:0]     arr  [CELLS];
  logic [7:0]     pbuf [ROW];
  logic [7:0]     rd_byte;

  logic cmd_s, adr_s, dat_s, rd_s;
  assign cmd_s = we & ~ce_n & cle;
  assign adr_s = we & ~ce_n & ale & ~cle;
  assign dat_s = we & ~ce_n & ~cle & ~ale;
  assign rd_s  = re & ~ce_n & ~we;

  logic [15:0] blk_start;
  logic        page_ok, blk_ok, ptr_in;
  logic [31:0] pbase, bbase;
  assign blk_start = row & ~16'(BLOCK_PAGES - 1);
  assign page_ok   = row < 16'(PAGES);
  assign blk_ok    = blk_start < 16'(PAGES);
  assign ptr_in    = ptr < CW'(ROW);
  assign pbase     = 32'(row) * ROW;
  assign bbase     = 32'(blk_start) * ROW;

  logic prog_go, erase_go;
  assign prog_go  = cmd_s && din == 8'h10 && mode == M_PROG && run && wp_n && page_ok;
  assign erase_go = cmd_s && din == 8'hD0 && mode == M_ERASE && acnt >= 2'd2 && wp_n && blk_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_READ; acnt <= '0; col <= '0; row <= '0;
      base <= '0; ptr <= '0; run <= 1'b0; idx <= '0;
    end else if (cmd_s) begin
      acnt <= '0;
      run  <= 1'b0;
      case (din)
        8'h00: begin mode <= M_READ; base <= '0; end
        8'h01: begin mode <= M_READ; base <= CW'(HALF); end
        8'h50: begin mode <= M_READ; base <= CW'(PAGE_BYTES); end
        8'h80: mode <= M_PROG;
        8'h10, 8'hD0: begin mode <= M_IDLE; base <= '0; end
        8'h60: mode <= M_ERASE;
        8'h70: mode <= M_STAT;
        8'h90: mode <= M_ID;
        8'hFF: begin mode <= M_READ; base <= '0; row <= '0; col <= '0; ptr <= '0; end
        default: mode <= M_IDLE;
      endcase
    end else if (adr_s) begin
      if (acnt != 2'd3) acnt <= acnt + 2'd1;
      case (mode)
        M_READ, M_PROG:
          case (acnt)
            2'd0: col <= din;
            2'd1: row[7:0] <= din;
            2'd2: begin
              row[15:8] <= din;
              run  <= 1'b1;
              ptr  <= base + CW'(col);
              base <= '0;
            end
            default: ;
          endcase
        M_ERASE:
          case (acnt)
            2'd0: row[7:0]  <= din;
            2'd1: row[15:8] <= din;
            default: ;
          endcase
        M_ID:
          if (acnt == 2'd0) begin run <= 1'b1; idx <= '0; end
        default: ;
      endcase
    end else if (dat_s) begin
      if (mode == M_PROG && run && ptr_in) ptr <= ptr + CW'(1);
    end else if (rd_s) begin
      if (mode == M_READ && run && ptr_in) ptr <= ptr + CW'(1);
      if (mode == M_ID && run && idx < 3'd4) idx <= idx + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd_s && din == 8'h80) begin
      for (int j = 0; j < ROW; j++) pbuf[j] <= 8'hFF;
    end else if (dat_s && mode == M_PROG && run && ptr_in) begin
      pbuf[RW'(ptr)] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < CELLS; k++) arr[k] <= 8'hFF;
    end else if (prog_go) begin
      for (int j = 0; j < ROW; j++)
        arr[AW'(pbase + 32'(j))] <= arr[AW'(pbase + 32'(j))] & pbuf[j];
    end else if (erase_go) begin
      for (int k = 0; k < BLOCK_PAGES * ROW; k++)
        if (bbase + 32'(k) < 32'(CELLS)) arr[AW'(bbase + 32'(k))] <= 8'hFF;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (!ce_n) begin
      case (mode)
        M_STAT: rd_byte = {wp_n, 1'b1, 6'b0};
        M_ID:
          if (run)
            case (idx)
              3'd0: rd_byte = MFR_ID;
              3'd1: rd_byte = DEV_ID;
              3'd2: rd_byte = ID_PAD;
              3'd3: rd_byte = 8'hC0;
              default: rd_byte = 8'h00;
            endcase
        M_READ:
          if (run && page_ok && ptr_in) rd_byte = arr[AW'(pbase + 32'(ptr))];
        default: ;
      endcase
    end
  end

  assign dout = rd_byte;
  assign rb   = 1'b1;

  a_r2_ce_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> dout == 8'h00);
  a_r3_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_READ && run && rd_s && ptr_in) |=> ptr == $past(ptr) + CW'(1));
  a_r5_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == M_READ && !ptr_in && !cmd_s && !adr_s) |=> $stable(ptr));
  a_r6_buf_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_s && din == 8'h80) |=> pbuf[0] == 8'hFF && pbuf[ROW-1] == 8'hFF);
  a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STAT && !cmd_s) |=> mode == M_STAT);
  a_r10_id_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= 3'd4);
  a_r11_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_s && din == 8'hFF) |=> (mode == M_READ && !run && acnt == 2'd0 && base == '0));
endmodule

// File: tb/nand_sp_model_tb.sv
module nand_sp_model_tb_top;
  localparam int PAGE_BYTES = 64;
  localparam int PAGES = 32;
  localparam int BLOCK_PAGES = 16;
  localparam int ROW = PAGE_BYTES + PAGE_BYTES / 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cle = 0, ale = 0, ce_n = 1, wp_n = 1, we = 0, re = 0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic rb;
  int total = 0, bad = 0;
  logic finished = 1'b0;
  logic [7:0] m [PAGES*ROW];

  always #10 clk = ~clk;

  nand_sp_model #(.PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES), .BLOCK_PAGES(BLOCK_PAGES),
                  .MFR_ID(8'h2C), .DEV_ID(8'h75), .ID_PAD(8'hA5)) dut_i (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .ce_n(ce_n), .wp_n(wp_n),
    .we(we), .re(re), .din(din), .dout(dout), .rb(rb));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic c, input logic a, input logic [7:0] b);
    cle = c; ale = a; din = b; we = 1'b1;
    @(negedge clk);
    #1 we = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b); pulse(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b); pulse(1'b0, 1'b1, b); endtask
  task automatic wdat(input logic [7:0] b); pulse(1'b0, 1'b0, b); endtask

  task automatic rdb(output logic [7:0] v);
    #1 v = dout;
    re = 1'b1;
    @(negedge clk);
    #1 re = 1'b0;
  endtask

  function automatic int offs(input logic [7:0] op);
    if (op == 8'h01) return PAGE_BYTES / 2;
    if (op == 8'h50) return PAGE_BYTES;
    return 0;
  endfunction

  task automatic read_chk(input logic [7:0] op, input int col, input int page,
                          input int n, input string tag);
    logic [7:0] v, e;
    int p;
    cmd(op); adr(8'(col)); adr(8'(page)); adr(8'(page >> 8));
    for (int i = 0; i < n; i++) begin
      rdb(v);
      p = offs(op) + col + i;
      e = (page < PAGES && p < ROW) ? m[page*ROW + p] : 8'h00;
      chk(tag, v, e);
    end
  endtask

  task automatic prog(input logic [7:0] op, input int col, input int page,
                      input int n, input logic [7:0] first, input logic [7:0] step);
    logic [7:0] b;
    int p;
    if (op != 8'h00) cmd(op);
    cmd(8'h80); adr(8'(col)); adr(8'(page)); adr(8'(page >> 8));
    for (int i = 0; i < n; i++) begin
      b = first + 8'(i) * step;
      wdat(b);
      p = offs(op) + col + i;
      if (wp_n && page < PAGES && p < ROW) m[page*ROW + p] = m[page*ROW + p] & b;
    end
    cmd(8'h10);
  endtask

  task automatic erase(input int page);
    int s;
    cmd(8'h60); adr(8'(page)); adr(8'(page >> 8)); cmd(8'hD0);
    s = page & ~(BLOCK_PAGES - 1);
    if (wp_n && s < PAGES)
      for (int k = 0; k < BLOCK_PAGES * ROW; k++)
        if (s*ROW + k < PAGES*ROW) m[s*ROW + k] = 8'hFF;
  endtask

  task automatic t_reset_state();
    #1 chk("R2 dout after reset", dout, 8'h00);
    chk("R2 rb ready", {7'b0, rb}, 8'h01);
    ce_n = 1'b0;
    read_chk(8'h00, 0, 10, 3, "R12 erased power-up");
  endtask

  task automatic t_id();
    logic [7:0] v;
    cmd(8'h90); adr(8'h00);
    rdb(v); chk("R10 mfr", v, 8'h2C);
    rdb(v); chk("R10 dev", v, 8'h75);
    rdb(v); chk("R10 pad", v, 8'hA5);
    rdb(v); chk("R10 planes", v, 8'hC0);
    rdb(v); chk("R10 past end", v, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v;
    cmd(8'h70);
    rdb(v); chk("R9 status", v, 8'hC0);
    rdb(v); chk("R9 sticky", v, 8'hC0);
    wp_n = 1'b0;
    rdb(v); chk("R9 protect bit", v, 8'h40);
    wp_n = 1'b1;
  endtask

  task automatic t_program_and();
    prog(8'h00, 5, 3, 6, 8'h3C, 8'h11);
    read_chk(8'h00, 3, 3, 10, "R3 R6 program readback");
    prog(8'h00, 5, 3, 6, 8'hF0, 8'h07);
    read_chk(8'h00, 4, 3, 8, "R6 AND merge");
    read_chk(8'h00, 0, 4, 4, "R6 neighbour page");
  endtask

  task automatic t_offsets();
    prog(8'h01, 1, 3, 4, 8'h5A, 8'h01);
    read_chk(8'h01, 0, 3, 6, "R4 second half");
    read_chk(8'h00, 32, 3, 4, "R4 one-shot offset");
    prog(8'h50, 0, 3, 4, 8'h81, 8'h02);
    read_chk(8'h50, 0, 3, 4, "R4 R5 spare then stop");
    read_chk(8'h00, 62, 3, 5, "R5 run into spare");
  endtask

  task automatic t_overlength();
    prog(8'h00, 60, 5, 10, 8'h10, 8'h01);
    read_chk(8'h00, 58, 5, 10, "R6 drop past spare");
  endtask

  task automatic t_protect();
    wp_n = 1'b0;
    prog(8'h00, 0, 6, 4, 8'h00, 8'h00);
    erase(3);
    wp_n = 1'b1;
    read_chk(8'h00, 0, 6, 4, "R8 program blocked");
    read_chk(8'h00, 4, 3, 4, "R8 erase blocked");
  endtask

  task automatic t_erase();
    prog(8'h00, 0, 16, 3, 8'h12, 8'h01);
    prog(8'h00, 0, 15, 3, 8'h21, 8'h01);
    erase(7);
    read_chk(8'h00, 4, 3, 4, "R7 block erased");
    read_chk(8'h50, 0, 5, 2, "R7 spare erased");
    read_chk(8'h00, 0, 15, 3, "R7 last page of block");
    read_chk(8'h00, 0, 16, 3, "R7 next block kept");
  endtask

  task automatic t_out_of_range();
    prog(8'h00, 0, 40, 3, 8'h00, 8'h00);
    erase(40);
    read_chk(8'h00, 0, 40, 2, "R12 out-of-range read");
    read_chk(8'h00, 0, 16, 3, "R12 no alias");
  endtask

  task automatic t_ce_and_reset();
    logic [7:0] v;
    cmd(8'h00); adr(8'h00); adr(8'd16); adr(8'h00);
    rdb(v); chk("R3 first byte", v, m[16*ROW]);
    ce_n = 1'b1;
    #1 chk("R2 ce high quiet", dout, 8'h00);
    cmd(8'h70);
    ce_n = 1'b0;
    rdb(v); chk("R1 ce gating", v, m[16*ROW + 1]);
    cmd(8'hFF);
    rdb(v); chk("R11 abandoned read", v, 8'h00);
    rdb(v); chk("R11 stays idle", v, 8'h00);
    cmd(8'h70);
    rdb(v); chk("R11 ready after reset", v, 8'hC0);
  endtask

  initial begin
    for (int k = 0; k < PAGES*ROW; k++) m[k] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_id();
    t_status();
    t_program_and();
    t_offsets();
    t_overlength();
    t_protect();
    t_erase();
    t_out_of_range();
    t_ce_and_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule